// File: doc/BRIEF.md
# Header-Driven Register Script Engine

This block fetches register-write scripts from memory and replays them onto an internal register bus without software involvement. Software places a header in memory and writes its byte address into the header-address register, which starts the engine. The header names up to eight bodies. Each body is a packed run of 8-byte entries: a register address word followed by a data word. The engine reads the header, walks the bodies in slot order, and turns every entry into one write on the register write port.

Header layout, in 32-bit words from the header base: word 0 holds the count of bodies beyond the first. Words 1+2k and 2+2k hold the byte length and the base address of body slot k, for k = 0..7. Word 17 holds the next-header address and word 18 holds the flag word. When a header is finished, flag bit 0 sends the engine on to the next header by itself. Flag bit 1 raises a sticky end interrupt. Software chains headers by setting bit 0 on all but the last and bit 1 on the last only.

The memory port and the register write port are valid/ready. A request or write stays valid with its payload unchanged until ready is seen high at a clock edge. Only one memory read is outstanding at a time. The engine raises the response ready only while it waits for the data of the read it has issued, and it takes the data on the first edge where response valid and ready are both high. The write port may be stalled for any length of time. The script then pauses, and no entry is lost or reordered.

Top module: `dlist_engine`

## Requirements
- R1: After reset the status register reads 0, the interrupt is low, and neither a memory request nor a register write is valid.
- R2: A write of the header address (csr_sel = 0) while idle starts a run. The first read is at the header base, followed by the length and address words of each used slot, then the next-header word (base + 68) and the flag word (base + 72), in that order.
- R3: The engine processes (count + 1) bodies in slot order, where count is word 0. A count above 7 is treated as 7. Slots beyond the last used one are never read.
- R4: A body's entry count is its byte length divided by 8. The three low bits are ignored, and the count is capped at 256 entries.
- R5: A body whose entry count is zero is skipped without any memory read. For every other entry, the address word is read, then the data word at +4.
- R6: When flag bit 0 is set, the engine loads the next-header address after the last body and processes that header without any CPU write.
- R7: When flag bit 1 is set, the sticky interrupt (status bit 1) rises only after the header's last register write has been accepted. Writing status with bit 1 = 1 clears it. A new set in the same cycle wins over the clear.
- R8: A header-address write while the engine is busy is ignored: it changes neither the run nor the read-back value of csr_sel = 0.
- R9: mrq_valid and mrq_addr hold until mrq_ready. No new request is issued while a response is still awaited.
- R10: Register writes leave in strict entry order. wr_valid, wr_addr and wr_data hold until wr_ready.
- R11: Status bit 0 (busy) is 1 from the cycle after a start until the run ends, and no memory traffic happens while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register port write strobe |
| csr_sel | input | 2 | Register select: 0 header address, 1 status |
| csr_wdata | input | 32 | Register port write data |
| csr_rdata | output | 32 | Read data for csr_sel (status: bit 0 busy, bit 1 interrupt) |
| mrq_valid | output | 1 | Memory read request valid |
| mrq_ready | input | 1 | Memory read request accepted |
| mrq_addr | output | AW | Byte address of the requested word |
| mrs_valid | input | 1 | Memory response valid |
| mrs_ready | output | 1 | Engine awaits a response |
| mrs_data | input | 32 | Memory response word |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Register write accepted |
| wr_addr | output | 32 | Register write address |
| wr_data | output | 32 | Register write data |
| irq | output | 1 | Sticky end interrupt |

## Verification
A wrong sequencer state shows at once on the memory port. A misdecoded count or length puts a read at an address that differs from the expected sequence, or adds or drops reads within a few cycles of the header fetch. A slip in the entry counter or slot index shows on the write port as a wrong address/data pair at the next entry. A wrong end decision shows as an interrupt that rises too early or not at all, or as busy staying high or dropping while a chained header remains. The bench compares full read and write logs against its own model, so any such fault is caught on the first divergent transfer.

// File: rtl/dl_pkg.sv
package dl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CNT, ST_SLEN, ST_SADR, ST_NEXT, ST_FLAGS,
    ST_BCHK, ST_EADR, ST_EDAT, ST_PUSH, ST_END
  } seq_state_e;

  typedef enum logic [1:0] {RD_IDLE, RD_REQ, RD_RSP} rd_state_e;

  localparam logic [1:0] SEL_HDR  = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam int FLAG_CHAIN = 0;
  localparam int FLAG_IRQ   = 1;
  localparam int STAT_BUSY  = 0;
  localparam int STAT_IRQ   = 1;
endpackage

// File: rtl/dl_mem_rd.sv
module dl_mem_rd
  import dl_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] go_addr,
  output logic          mrq_valid,
  input  logic          mrq_ready,
  output logic [AW-1:0] mrq_addr,
  input  logic          mrs_valid,
  output logic          mrs_ready,
  input  logic [31:0]   mrs_data,
  output logic          done,
  output logic [31:0]   data
);
  rd_state_e     st;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RD_IDLE;
      addr_q <= '0;
    end else begin
      case (st)
        RD_IDLE: if (go) begin
          addr_q <= go_addr;
          st     <= RD_REQ;
        end
        RD_REQ:  if (mrq_ready) st <= RD_RSP;
        RD_RSP:  if (mrs_valid) st <= RD_IDLE;
        default: st <= RD_IDLE;
      endcase
    end
  end

  assign mrq_valid = (st == RD_REQ);
  assign mrq_addr  = addr_q;
  assign mrs_ready = (st == RD_RSP);
  assign done      = (st == RD_RSP) && mrs_valid;
  assign data      = mrs_data;
endmodule

// File: rtl/dl_wr_stage.sv
module dl_wr_stage #(
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [RW-1:0] push_addr,
  input  logic [31:0]   push_data,
  output logic          space,
  output logic          empty,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [RW-1:0] wr_addr,
  output logic [31:0]   wr_data
);
  logic          full_q;
  logic [RW-1:0] a_q;
  logic [31:0]   d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      a_q    <= '0;
      d_q    <= '0;
    end else if (push) begin
      full_q <= 1'b1;
      a_q    <= push_addr;
      d_q    <= push_data;
    end else if (wr_ready) begin
      full_q <= 1'b0;
    end
  end

  assign space    = !full_q || wr_ready;
  assign empty    = !full_q;
  assign wr_valid = full_q;
  assign wr_addr  = a_q;
  assign wr_data  = d_q;
endmodule

// File: rtl/dl_csr.sv
module dl_csr
  import dl_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_we,
  input  logic [1:0]    csr_sel,
  input  logic [31:0]   csr_wdata,
  output logic [31:0]   csr_rdata,
  input  logic          busy,
  input  logic          irq_set,
  output logic          start,
  output logic [AW-1:0] start_addr,
  output logic          irq
);
  logic [AW-1:0] hdr_q;
  logic          irq_q;
  logic          irq_clr;

  assign start      = csr_we && (csr_sel == SEL_HDR) && !busy;
  assign start_addr = csr_wdata[AW-1:0];
  assign irq_clr    = csr_we && (csr_sel == SEL_STAT) && csr_wdata[STAT_IRQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (start) hdr_q <= csr_wdata[AW-1:0];
      if (irq_set)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_sel)
      SEL_HDR:  csr_rdata[AW-1:0] = hdr_q;
      SEL_STAT: begin
        csr_rdata[STAT_BUSY] = busy;
        csr_rdata[STAT_IRQ]  = irq_q;
      end
      default:  csr_rdata = '0;
    endcase
  end

  assign irq = irq_q;
endmodule

// File: rtl/dl_seq.sv
module dl_seq
  import dl_pkg::*;
#(
  parameter int AW          = 32,
  parameter int RW          = 32,
  parameter int MAX_BODIES  = 8,
  parameter int MAX_ENTRIES = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          rd_go,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_done,
  input  logic [31:0]   rd_data,
  output logic          push,
  output logic [RW-1:0] push_addr,
  output logic [31:0]   push_data,
  input  logic          wr_space,
  input  logic          wr_empty,
  output logic          busy,
  output logic          irq_set
);
  localparam int SW       = (MAX_BODIES > 1) ? $clog2(MAX_BODIES) : 1;
  localparam int EW       = $clog2(MAX_ENTRIES + 1);
  localparam int NEXT_OFS = 4 + 8 * MAX_BODIES;
  localparam int FLAG_OFS = NEXT_OFS + 4;

  seq_state_e    st;
  logic [AW-1:0] hdr_q, next_q;
  logic [1:0]    flags_q;
  logic [SW-1:0] last_q, slot_q;
  logic [EW-1:0] ent_q;
  logic          pend_q;
  logic [RW-1:0] ra_q;
  logic [31:0]   rd_q;
  logic [EW-1:0] len_q [MAX_BODIES];
  logic [AW-1:0] adr_q [MAX_BODIES];

  logic          is_rd;
  logic [31:0]   ent_raw;
  logic [EW-1:0] len_val;
  logic [SW-1:0] cnt_val;
  logic [EW-1:0] cur_len;
  logic [AW-1:0] cur_adr;
  logic          slot_last, ent_last;

  assign cur_len   = len_q[slot_q];
  assign cur_adr   = adr_q[slot_q];
  assign slot_last = (slot_q == last_q);
  assign ent_last  = ((ent_q + 1'b1) == cur_len);
  assign ent_raw   = rd_data >> 3;
  assign len_val   = (ent_raw > 32'(MAX_ENTRIES)) ? EW'(MAX_ENTRIES) : ent_raw[EW-1:0];
  assign cnt_val   = (rd_data > 32'(MAX_BODIES - 1)) ? SW'(MAX_BODIES - 1) : rd_data[SW-1:0];

  always_comb begin
    is_rd   = 1'b1;
    rd_addr = hdr_q;
    case (st)
      ST_CNT:   rd_addr = hdr_q;
      ST_SLEN:  rd_addr = hdr_q + AW'(4) + (AW'(slot_q) << 3);
      ST_SADR:  rd_addr = hdr_q + AW'(8) + (AW'(slot_q) << 3);
      ST_NEXT:  rd_addr = hdr_q + AW'(NEXT_OFS);
      ST_FLAGS: rd_addr = hdr_q + AW'(FLAG_OFS);
      ST_EADR:  rd_addr = cur_adr + (AW'(ent_q) << 3);
      ST_EDAT:  rd_addr = cur_adr + (AW'(ent_q) << 3) + AW'(4);
      default:  is_rd = 1'b0;
    endcase
  end

  assign rd_go     = is_rd && !pend_q;
  assign push      = (st == ST_PUSH) && wr_space;
  assign push_addr = ra_q;
  assign push_data = rd_q;
  assign busy      = (st != ST_IDLE);
  assign irq_set   = (st == ST_END) && wr_empty && flags_q[FLAG_IRQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (rd_done) begin
      pend_q <= 1'b0;
    end else if (rd_go) begin
      pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < MAX_BODIES; k++) begin
        len_q[k] <= '0;
        adr_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < MAX_BODIES; k++) begin
        if (rd_done && (st == ST_SLEN) && (slot_q == SW'(k))) len_q[k] <= len_val;
        if (rd_done && (st == ST_SADR) && (slot_q == SW'(k))) adr_q[k] <= rd_data[AW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      hdr_q   <= '0;
      next_q  <= '0;
      flags_q <= '0;
      last_q  <= '0;
      slot_q  <= '0;
      ent_q   <= '0;
      ra_q    <= '0;
      rd_q    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          hdr_q <= start_addr;
          st    <= ST_CNT;
        end
        ST_CNT: if (rd_done) begin
          last_q <= cnt_val;
          slot_q <= '0;
          st     <= ST_SLEN;
        end
        ST_SLEN: if (rd_done) st <= ST_SADR;
        ST_SADR: if (rd_done) begin
          if (slot_last) st <= ST_NEXT;
          else begin
            slot_q <= slot_q + 1'b1;
            st     <= ST_SLEN;
          end
        end
        ST_NEXT: if (rd_done) begin
          next_q <= rd_data[AW-1:0];
          st     <= ST_FLAGS;
        end
        ST_FLAGS: if (rd_done) begin
          flags_q <= rd_data[1:0];
          slot_q  <= '0;
          st      <= ST_BCHK;
        end
        ST_BCHK: begin
          ent_q <= '0;
          if (cur_len != '0) st <= ST_EADR;
          else if (slot_last) st <= ST_END;
          else slot_q <= slot_q + 1'b1;
        end
        ST_EADR: if (rd_done) begin
          ra_q <= rd_data[RW-1:0];
          st   <= ST_EDAT;
        end
        ST_EDAT: if (rd_done) begin
          rd_q <= rd_data;
          st   <= ST_PUSH;
        end
        ST_PUSH: if (wr_space) begin
          if (!ent_last) begin
            ent_q <= ent_q + 1'b1;
            st    <= ST_EADR;
          end else if (slot_last) begin
            st <= ST_END;
          end else begin
            slot_q <= slot_q + 1'b1;
            st     <= ST_BCHK;
          end
        end
        ST_END: if (wr_empty) begin
          if (flags_q[FLAG_CHAIN]) begin
            hdr_q <= next_q;
            st    <= ST_CNT;
          end else begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dlist_engine.sv
module dlist_engine #(
  parameter int AW          = 32,
  parameter int MAX_BODIES  = 8,
  parameter int MAX_ENTRIES = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_we,
  input  logic [1:0]    csr_sel,
  input  logic [31:0]   csr_wdata,
  output logic [31:0]   csr_rdata,
  output logic          mrq_valid,
  input  logic          mrq_ready,
  output logic [AW-1:0] mrq_addr,
  input  logic          mrs_valid,
  output logic          mrs_ready,
  input  logic [31:0]   mrs_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [31:0]   wr_addr,
  output logic [31:0]   wr_data,
  output logic          irq
);
  logic          busy, start, irq_set;
  logic [AW-1:0] start_addr, rd_addr;
  logic          rd_go, rd_done;
  logic [31:0]   rd_data;
  logic          push, wr_space, wr_empty;
  logic [31:0]   push_addr, push_data;

  dl_csr #(.AW(AW)) u_csr (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .busy(busy),
    .irq_set(irq_set), .start(start), .start_addr(start_addr), .irq(irq)
  );

  dl_seq #(.AW(AW), .RW(32), .MAX_BODIES(MAX_BODIES), .MAX_ENTRIES(MAX_ENTRIES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .rd_go(rd_go), .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data),
    .push(push), .push_addr(push_addr), .push_data(push_data),
    .wr_space(wr_space), .wr_empty(wr_empty), .busy(busy), .irq_set(irq_set)
  );

  dl_mem_rd #(.AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .go(rd_go), .go_addr(rd_addr),
    .mrq_valid(mrq_valid), .mrq_ready(mrq_ready), .mrq_addr(mrq_addr),
    .mrs_valid(mrs_valid), .mrs_ready(mrs_ready), .mrs_data(mrs_data),
    .done(rd_done), .data(rd_data)
  );

  dl_wr_stage #(.RW(32)) u_wr (
    .clk(clk), .rst_n(rst_n), .push(push), .push_addr(push_addr),
    .push_data(push_data), .space(wr_space), .empty(wr_empty),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: rtl/dlist_engine_chk.sv
module dlist_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          csr_we,
  input logic [1:0]    csr_sel,
  input logic          csr_clr_bit,
  input logic          busy,
  input logic          mrq_valid,
  input logic          mrq_ready,
  input logic [AW-1:0] mrq_addr,
  input logic          mrs_ready,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [31:0]   wr_addr,
  input logic [31:0]   wr_data,
  input logic          irq
);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mrq_valid && !mrq_ready |=> mrq_valid && $stable(mrq_addr));

  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_ready |-> !mrq_valid);

  p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(csr_we && csr_sel == 2'd1 && csr_clr_bit) |=> irq);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mrq_valid && !mrs_ready && !wr_valid);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && csr_we && csr_sel == 2'd0 |=> busy);
endmodule

bind dlist_engine dlist_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
  .csr_clr_bit(csr_wdata[1]), .busy(busy), .mrq_valid(mrq_valid),
  .mrq_ready(mrq_ready), .mrq_addr(mrq_addr), .mrs_ready(mrs_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .irq(irq)
);

// File: tb/tb_dlist_engine.sv
`timescale 1ns/1ps
module tb_dlist_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_we = 1'b0;
  logic [1:0] csr_sel = 2'd0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic mrq_valid, mrs_ready, wr_valid, irq;
  logic mrq_ready = 1'b0;
  logic mrs_valid = 1'b0;
  logic wr_ready = 1'b0;
  logic [31:0] mrq_addr, mrs_data, wr_addr, wr_data;

  always #2.5 clk = ~clk;

  dlist_engine dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mrq_valid(mrq_valid),
    .mrq_ready(mrq_ready), .mrq_addr(mrq_addr), .mrs_valid(mrs_valid),
    .mrs_ready(mrs_ready), .mrs_data(mrs_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
  );

  logic [31:0] mem [0:8191];
  logic [31:0] rla [0:4095];
  logic [31:0] wla [0:4095];
  logic [31:0] wld [0:4095];
  logic [31:0] xra [0:4095];
  logic [31:0] xwa [0:4095];
  logic [31:0] xwd [0:4095];
  int nr, nw, xnr, xnw, irq_rises, hid;
  int total = 0, bad = 0;
  int bump;
  bit finished = 0;
  bit req_seen = 0, taken = 0, irq_prev = 0;
  logic [31:0] req_addr;
  logic [31:0] rnd = 32'h1234_5678;
  bit wr_stall = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: observes handshakes at the edge, pre-update values.
  always @(posedge clk) begin
    if (mrq_valid && mrq_ready) begin
      if (nr < 4096) rla[nr] = mrq_addr;
      nr++;
      req_seen = 1;
      req_addr = mrq_addr;
    end
    if (mrs_valid && mrs_ready) taken = 1;
    if (wr_valid && wr_ready) begin
      if (nw < 4096) begin wla[nw] = wr_addr; wld[nw] = wr_data; end
      nw++;
    end
    if (irq && !irq_prev) irq_rises++;
    irq_prev = irq;
  end

  // Responder: drives memory and sink inputs at the falling edge.
  initial begin
    int lat;
    bit waiting;
    lat = 0; waiting = 0;
    forever begin
      @(negedge clk);
      rnd = rnd * 32'd1103515245 + 32'd12345;
      mrq_ready = rnd[20] | rnd[23];
      wr_ready  = wr_stall ? 1'b0 : (rnd[25] | rnd[28]);
      if (taken) begin mrs_valid = 0; taken = 0; end
      if (req_seen) begin
        req_seen = 0;
        waiting = 1;
        lat = int'(rnd[17:16]) % 3;
      end
      if (waiting) begin
        if (lat == 0) begin
          mrs_valid = 1;
          mrs_data = mem[req_addr[14:2]];
          waiting = 0;
        end else lat--;
      end
    end
  end

  function automatic int alloc(input int bytes);
    int a;
    a = bump;
    bump = bump + ((bytes + 7) / 8) * 8;
    return a;
  endfunction

  function automatic logic [31:0] ent_a(input int h, input int b, input int i);
    return 32'hA000_0000 | (32'(h) << 16) | (32'(b) << 12) | 32'(i);
  endfunction

  function automatic logic [31:0] ent_d(input int h, input int b, input int i);
    return ~ent_a(h, b, i) + 32'(i * 3);
  endfunction

  // Builds one header plus its bodies and appends the expected traffic.
  task automatic add_hdr(input int base, input int cnt, input int bc [8],
                         input int flags, input int nxt);
    int used, e, ba;
    used = (cnt > 7) ? 8 : cnt + 1;
    mem[base/4] = 32'(cnt);
    mem[base/4 + 17] = 32'(nxt);
    mem[base/4 + 18] = 32'(flags);
    xra[xnr++] = 32'(base);
    for (int b = 0; b < 8; b++) begin
      e = bc[b] / 8;
      if (e > 256) e = 256;
      if (b >= used) e = 0;
      ba = alloc(e * 8 + 8);
      mem[base/4 + 1 + 2*b] = 32'(bc[b]);
      mem[base/4 + 2 + 2*b] = 32'(ba);
      if (b < used) begin
        xra[xnr++] = 32'(base + 4 + 8*b);
        xra[xnr++] = 32'(base + 8 + 8*b);
      end
      for (int i = 0; i < e; i++) begin
        mem[ba/4 + 2*i]     = ent_a(hid, b, i);
        mem[ba/4 + 2*i + 1] = ent_d(hid, b, i);
      end
    end
    xra[xnr++] = 32'(base + 68);
    xra[xnr++] = 32'(base + 72);
    for (int b = 0; b < used; b++) begin
      e = bc[b] / 8;
      if (e > 256) e = 256;
      ba = int'(mem[base/4 + 2 + 2*b]);
      for (int i = 0; i < e; i++) begin
        xra[xnr++] = 32'(ba + 8*i);
        xra[xnr++] = 32'(ba + 8*i + 4);
        xwa[xnw] = ent_a(hid, b, i);
        xwd[xnw] = ent_d(hid, b, i);
        xnw++;
      end
    end
    hid++;
  endtask

  task automatic clear_exp();
    nr = 0; nw = 0; xnr = 0; xnw = 0; irq_rises = 0; bump = 32'h100;
  endtask

  task automatic csr_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    csr_sel = sel; csr_wdata = d; csr_we = 1;
    @(negedge clk);
    csr_we = 0;
  endtask

  task automatic csr_read(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    csr_sel = sel;
    #0.5 d = csr_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    s = 32'h1;
    for (int n = 0; n < 20000 && s[0]; n++) csr_read(2'd1, s);
  endtask

  task automatic compare(input string tag);
    int ra_bad, wa_bad;
    ra_bad = -1; wa_bad = -1;
    check(nr == xnr, {tag, " R5 read count"}, 32'(nr), 32'(xnr));
    for (int i = 0; i < xnr && i < nr; i++)
      if (ra_bad < 0 && rla[i] !== xra[i]) ra_bad = i;
    check(ra_bad < 0, {tag, " R2 read order"}, (ra_bad < 0) ? 0 : rla[ra_bad],
          (ra_bad < 0) ? 0 : xra[ra_bad]);
    check(nw == xnw, {tag, " R3 write count"}, 32'(nw), 32'(xnw));
    for (int i = 0; i < xnw && i < nw; i++)
      if (wa_bad < 0 && (wla[i] !== xwa[i] || wld[i] !== xwd[i])) wa_bad = i;
    check(wa_bad < 0, {tag, " R10 write order"}, (wa_bad < 0) ? 0 : wla[wa_bad],
          (wa_bad < 0) ? 0 : xwa[wa_bad]);
  endtask

  task automatic run(input int base);
    csr_write(2'd0, 32'(base));
    wait_idle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int bc [8];
    int h0, h1, h2;
    logic [31:0] s;
    hid = 0;
    clear_exp();
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    csr_read(2'd1, s);
    check(s == 0, "R1 status after reset", s, 0);
    check(!mrq_valid && !wr_valid && !irq, "R1 ports quiet", {29'd0, mrq_valid, wr_valid, irq}, 0);

    // Sweep over body count with mixed sizes, including empty bodies.
    for (int n = 0; n < 8; n++) begin
      clear_exp();
      for (int b = 0; b < 8; b++) bc[b] = ((b + n) % 4) * 8 + ((n % 2) ? (b % 8) : 0);
      h0 = alloc(80);
      add_hdr(h0, n, bc, 2, 0);
      run(h0);
      compare($sformatf("sweep%0d R3", n));
      check(irq_rises == 1, "R7 irq on end", 32'(irq_rises), 1);
      csr_write(2'd1, 32'h2);
      csr_read(2'd1, s);
      check(s[1] == 1'b0, "R7 W1C clear", s, 0);
    end

    // R3: count above 7 saturates to eight bodies
    clear_exp();
    for (int b = 0; b < 8; b++) bc[b] = 8 * (b + 1);
    h0 = alloc(80);
    add_hdr(h0, 15, bc, 2, 0);
    run(h0);
    compare("R3 saturate");
    csr_write(2'd1, 32'h2);

    // R4: cap at 256 entries and low bits ignored
    clear_exp();
    bc = '{300*8, 3*8+5, 0, 0, 0, 0, 0, 0};
    h0 = alloc(80);
    add_hdr(h0, 1, bc, 2, 0);
    run(h0);
    compare("R4 cap");
    check(nw == 259, "R4 entry total", 32'(nw), 259);
    csr_write(2'd1, 32'h2);

    // R6/R7: chain of three headers, one interrupt at the end
    clear_exp();
    h0 = alloc(80); h1 = alloc(80); h2 = alloc(80);
    bc = '{16, 0, 24, 0, 0, 0, 0, 0};
    add_hdr(h0, 2, bc, 1, h1);
    bc = '{8, 40, 0, 0, 0, 0, 0, 0};
    add_hdr(h1, 1, bc, 1, h2);
    bc = '{0, 0, 0, 32, 0, 0, 0, 0};
    add_hdr(h2, 3, bc, 2, 0);
    run(h0);
    compare("R6 chain");
    check(irq_rises == 1, "R7 chain single irq", 32'(irq_rises), 1);
    csr_write(2'd1, 32'h2);

    // R7: no interrupt when the flag is clear
    clear_exp();
    bc = '{24, 0, 0, 0, 0, 0, 0, 0};
    h0 = alloc(80);
    add_hdr(h0, 0, bc, 0, 0);
    run(h0);
    compare("R7 noirq");
    csr_read(2'd1, s);
    check(s == 0 && irq_rises == 0, "R7 no irq flag clear", s, 0);

    // R8/R11: header write while busy is ignored; busy visible
    clear_exp();
    bc = '{8*40, 0, 0, 0, 0, 0, 0, 0};
    h0 = alloc(80);
    add_hdr(h0, 0, bc, 2, 0);
    h1 = alloc(80);
    mem[h1/4] = 0;
    wr_stall = 1;
    csr_write(2'd0, 32'(h0));
    repeat (30) @(negedge clk);
    csr_read(2'd1, s);
    check(s[0] == 1'b1, "R11 busy during run", s, 1);
    csr_write(2'd0, 32'(h1));
    csr_read(2'd0, s);
    check(s == 32'(h0), "R8 hdr readback unchanged", s, 32'(h0));
    wr_stall = 0;
    wait_idle();
    repeat (3) @(negedge clk);
    compare("R8 busy ignore");
    csr_read(2'd1, s);
    check(s[0] == 1'b0, "R11 idle after run", s, 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R11 actual=hung expected=idle");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule